// File: doc/BRIEF.md
# Decoder Self-Test Engine with Parity Checking

This block wraps a 3-to-8 one-hot decoder in a built-in self-test loop. A single-cycle start request launches an exhaustive sweep. A binary counter applies every select code to the decoder, one code per cycle. A parity checker then folds the eight decoder outputs with XOR. A healthy word has exactly one bit set, so odd parity counts as a pass and even parity raises an error. No expected output words are stored.

The engine reports that a sweep is running and that it has finished. It also keeps a sticky failure flag and the select code at which the first error was seen. A per-output fault-injection control can stick any decoder output at 0 or at 1, so the checker can be exercised on purpose. The current code, the observed word and the per-cycle parity verdict are visible at the ports.

Top module: `dec_bist`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `fail_o` are 0, and `fail_code_o` and `code_o` are 0.
- R2: A start pulse accepted while idle sets `busy_o` on the next cycle with `code_o` = 0. `code_o` then rises by one on every cycle up to 7.
- R3: With `flt_en_i` all zero, `dec_o` has only bit `code_o` set.
- R4: `par_err_o` is 1 exactly when `dec_o` has an even number of ones, including zero ones.
- R5: A sweep lasts exactly 8 busy cycles. On the clock edge that ends the cycle checking code 7, `busy_o` falls and `done_o` rises. `done_o` stays high until the next accepted start clears it.
- R6: `fail_o` is set when `par_err_o` is 1 during a busy cycle. It stays set until the next accepted start clears it.
- R7: `fail_code_o` holds the code of the first failing cycle of the sweep. Later failures in the same sweep do not change it.
- R8: When bit k of `flt_en_i` is 1, output k of `dec_o` is forced to bit k of `flt_val_i`. Bits of `flt_en_i` that are 0 leave the decoder output untouched.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. The count continues, the sweep length does not change, and `fail_o` is not cleared.
- R10: A faulty word with an odd number of ones, such as three bits set, gives `par_err_o` = 0 and escapes detection on that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sweep start request |
| flt_en_i | input | 8 | Per-output fault enable |
| flt_val_i | input | 8 | Forced value for each enabled output |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished |
| fail_o | output | 1 | Sticky failure flag |
| fail_code_o | output | 3 | Select code of the first failure |
| code_o | output | 3 | Select code currently applied |
| dec_o | output | 8 | Decoder output word as observed by the checker |
| par_err_o | output | 1 | Parity verdict for the current word |

## Verification
A clean sweep shows that every code yields its own one-hot word and that no error is flagged. The bench then runs one sweep for every single stuck-at-0 fault and every single stuck-at-1 fault, on every output. Each of these sweeps tells a lost bit (zero ones) from an extra bit (two ones), and each gives its own expected first failing code. A double stuck-at-1 fault produces three set bits on most codes, which shows the parity escape. The same fault is still caught on the codes that collide with the stuck outputs. A start request issued in mid-sweep, and a clean sweep run after a failing one, separate the ignored start from the accepted start.

// File: rtl/dec_bist_pkg.sv
package dec_bist_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/dec_bist_seq.sv
module dec_bist_seq
  import dec_bist_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             start_acc_o,
  output logic [SEL_W-1:0] code_o
);
  localparam logic [SEL_W-1:0] LAST = '1;

  seq_st_e          st_q;
  logic [SEL_W-1:0] cnt_q;
  logic             done_q;

  assign start_acc_o = start_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          cnt_q  <= '0;
          done_q <= 1'b0;
        end
        default: if (cnt_q == LAST) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign busy_o = (st_q == ST_RUN);
  assign done_o = done_q;
  assign code_o = cnt_q;
endmodule

// File: rtl/dec_bist_dut.sv
module dec_bist_dut #(
  parameter int SEL_W = 3,
  localparam int OUT_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OUT_N-1:0] flt_en_i,
  input  logic [OUT_N-1:0] flt_val_i,
  output logic [OUT_N-1:0] dec_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_out
    logic hit;
    assign hit      = (sel_i == SEL_W'(k));
    assign dec_o[k] = flt_en_i[k] ? flt_val_i[k] : hit;
  end
endmodule

// File: rtl/dec_bist_par.sv
module dec_bist_par #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              err_o
);
  // odd parity means pass
  assign err_o = ~(^word_i);
endmodule

// File: rtl/dec_bist.sv
module dec_bist #(
  parameter int SEL_W = 3,
  localparam int OUT_N = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OUT_N-1:0] flt_en_i,
  input  logic [OUT_N-1:0] flt_val_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [SEL_W-1:0] fail_code_o,
  output logic [SEL_W-1:0] code_o,
  output logic [OUT_N-1:0] dec_o,
  output logic             par_err_o
);
  logic             start_acc;
  logic             fail_q;
  logic [SEL_W-1:0] fail_code_q;

  dec_bist_seq #(.SEL_W(SEL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .start_acc_o (start_acc),
    .code_o      (code_o)
  );

  dec_bist_dut #(.SEL_W(SEL_W)) u_dut (
    .sel_i     (code_o),
    .flt_en_i  (flt_en_i),
    .flt_val_i (flt_val_i),
    .dec_o     (dec_o)
  );

  dec_bist_par #(.WORD_W(OUT_N)) u_par (
    .word_i (dec_o),
    .err_o  (par_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_code_q <= '0;
    end else if (start_acc) begin
      fail_q      <= 1'b0;
      fail_code_q <= '0;
    end else if (busy_o && par_err_o && !fail_q) begin
      fail_q      <= 1'b1;
      fail_code_q <= code_o;
    end
  end

  assign fail_o      = fail_q;
  assign fail_code_o = fail_code_q;
endmodule

// File: rtl/dec_bist_chk.sv
module dec_bist_chk #(
  parameter int SEL_W = 3,
  localparam int OUT_N = 1 << SEL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [OUT_N-1:0] flt_en_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [SEL_W-1:0] fail_code_o,
  input logic [SEL_W-1:0] code_o,
  input logic [OUT_N-1:0] dec_o,
  input logic             par_err_o
);
  localparam logic [SEL_W-1:0] LAST = '1;
  logic acc;
  assign acc = start_i && !busy_o;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o && (code_o == '0));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && code_o != LAST) |=> busy_o && (code_o == SEL_W'($past(code_o) + 1'b1)));
  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_en_i == '0) |-> ($countones(dec_o) == 1) && dec_o[code_o]);
  assert_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && code_o == LAST) |=> done_o && !busy_o);
  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !acc) |=> done_o);
  assert_fail_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && par_err_o) |=> fail_o);
  assert_fail_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !acc) |=> fail_o);
  assert_code_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !acc) |=> $stable(fail_code_o));
  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && code_o != LAST) |=> busy_o && (code_o != '0));
endmodule

bind dec_bist dec_bist_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .flt_en_i    (flt_en_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_code_o (fail_code_o),
  .code_o      (code_o),
  .dec_o       (dec_o),
  .par_err_o   (par_err_o)
);

// File: tb/dec_bist_tb_top.sv
`timescale 1ns/1ps
module dec_bist_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] flt_en = '0;
  logic [7:0] flt_val = '0;
  logic       busy, done, fail, par_err;
  logic [2:0] fail_code, code;
  logic [7:0] dec;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dec_bist dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .flt_en_i (flt_en), .flt_val_i (flt_val),
    .busy_o (busy), .done_o (done), .fail_o (fail),
    .fail_code_o (fail_code), .code_o (code),
    .dec_o (dec), .par_err_o (par_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  function automatic logic [7:0] exp_word(input int c, input logic [7:0] en, input logic [7:0] val);
    logic [7:0] w;
    w = 8'(1) << c;
    return (w & ~en) | (val & en);
  endfunction

  // full sweep with per-cycle checks; returns nothing, checks result flags
  task automatic sweep(input logic [7:0] en, input logic [7:0] val, input string tag);
    logic exp_fail = 1'b0;
    logic [2:0] exp_code = '0;
    flt_en = en; flt_val = val;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 8; c++) begin
      logic [7:0] w;
      w = exp_word(c, en, val);
      chk({tag, " R2 code"}, 32'(code), 32'(c));
      chk({tag, " R2 busy"}, 32'(busy), 1);
      chk({tag, " R8 word"}, 32'(dec), 32'(w));
      chk({tag, " R4 parity"}, 32'(par_err), 32'($countones(w) % 2 == 0));
      if (!exp_fail && ($countones(w) % 2 == 0)) begin
        exp_fail = 1'b1; exp_code = 3'(c);
      end
      @(negedge clk);
    end
    chk({tag, " R5 done"}, 32'(done), 1);
    chk({tag, " R5 busy low"}, 32'(busy), 0);
    chk({tag, " R6 fail"}, 32'(fail), 32'(exp_fail));
    chk({tag, " R7 fail_code"}, 32'(fail_code), 32'(exp_code));
  endtask

  initial begin
    #1;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 fail", 32'(fail), 0);
    chk("R1 fail_code", 32'(fail_code), 0);
    chk("R1 code", 32'(code), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'(busy), 0);

    // R3: clean sweep, one-hot words
    sweep(8'h00, 8'h00, "clean R3");

    // R8: every single stuck-at, each output
    for (int k = 0; k < 8; k++) begin
      sweep(8'(1) << k, 8'h00, "stuck0");
      sweep(8'(1) << k, 8'(1) << k, "stuck1");
    end

    // R10: outputs 5 and 6 stuck at 1; code 0 word has three ones and escapes
    flt_en = 8'h60; flt_val = 8'h60;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10 three-bit word", 32'(dec), 32'h61);
    chk("R10 no parity error", 32'(par_err), 0);
    for (int c = 0; c < 8; c++) @(negedge clk);
    chk("R10 caught later R7", 32'(fail_code), 5);
    chk("R10 fail", 32'(fail), 1);

    // R9: start mid-sweep ignored, fail not cleared
    flt_en = 8'h01; flt_val = 8'h00;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 pre code", 32'(code), 2);
    flt_en = 8'h00;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9 code continues", 32'(code), 3);
    chk("R9 fail kept", 32'(fail), 1);
    for (int c = 0; c < 4; c++) @(negedge clk);
    chk("R9 still busy at 7", 32'(busy), 1);
    chk("R9 code 7", 32'(code), 7);
    @(negedge clk);
    chk("R9 R5 done on time", 32'(done), 1);
    @(negedge clk);
    chk("R5 done held", 32'(done), 1);
    chk("R6 fail held idle", 32'(fail), 1);

    // R6: accepted start clears fail and done
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R6 fail cleared", 32'(fail), 0);
    chk("R5 done cleared", 32'(done), 0);
    for (int c = 0; c < 8; c++) @(negedge clk);
    chk("R6 clean after fail", 32'(fail), 0);
    summary();
  end
endmodule